// File: doc/BRIEF.md
# Key-Locked ECC Error Log and Interrupt Registers

This block is the error-reporting register file of a multi-channel memory controller. The ECC datapath detects errors and sends strobes to it. Each strobe carries a channel number, a correctable or uncorrectable flag, a source lane and the decoded DRAM coordinates of the failing access. For every channel and error class, the block keeps a status count and a log of the coordinates of the first error seen since that count was last cleared. It also sets a per-source interrupt status bit. Interrupt status is masked by an enable register and reduced to one interrupt line.

Software reaches the block through a simple single-cycle register bus. Read data is combinational from the address. A protection register guards every write. The block leaves reset locked. It accepts writes to its other registers only after a 32-bit key has been written to the protection register. A write of 1 to that register locks the block again. A typical error handler does the following in order: it reads the status counts and logs, unlocks the block, writes 0 to the status counts, writes the interrupt status it read back to the interrupt status register, and locks the block again.

Top module: `ecc_errlog_regs`

## Requirements
- R1: After reset the block is locked, and the protection register (offset 0x00C) reads 1. Interrupt status, interrupt enable and every status count read 0, and `irq` is low.
- R2: A write of 0xF9E8D7C6 to offset 0x00C unlocks the block, and the register then reads 0. A write of 1 locks it. A write of any other value leaves the lock state unchanged.
- R3: While the block is locked, writes to every register except the protection register have no effect.
- R4: Each error strobe adds one to the status count of its channel and class. The count saturates at 2^STAT_W-1.
- R5: When a strobe arrives and the addressed count is 0, the log captures the coordinates. The low log word holds, from bit 0 upward: burst (3 bits), logical rank (3), rank (2), bank group (2), bank (2), column (10) and row[9:0]. Bits 7:0 of the high log word hold row[17:10]. While the count is nonzero, later strobes leave the log unchanged.
- R6: While the block is unlocked, a write of 0 to a status count clears it. A write of a nonzero value to a status count is ignored.
- R7: A strobe sets interrupt status bit 15+src if it is correctable and bit 11+src if it is uncorrectable. The interrupt status register is at offset 0x014. An unlocked write to it clears each bit that is written as 1. A bit set by a strobe in the same cycle stays set.
- R8: An unlocked write to offset 0x020 sets the enable bits that are written as 1. An unlocked write to offset 0x024 clears the enable bits that are written as 1. Only bits 18:11 exist. Offset 0x020 reads the enable mask and offset 0x024 reads 0.
- R9: `irq` is high exactly when some interrupt status bit and its matching enable bit are both set.
- R10: If a status clear and a strobe for the same count fall in the same cycle, the count becomes 1 and the log captures the new coordinates.
- R11: The records of channel ch and class ue (ue=1 for uncorrectable) sit at 0x100 + 32·ch + 16·ue. Offset +0 is the count, +4 the low log word and +8 the high log word. Every unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| evt_valid | input | 1 | Error strobe |
| evt_chan | input | $clog2(NUM_CH) | Channel of the error |
| evt_ue | input | 1 | 1 = uncorrectable, 0 = correctable |
| evt_src | input | 2 | Source lane within the class |
| evt_burst | input | 3 | Burst position |
| evt_lrank | input | 3 | Logical rank |
| evt_rank | input | 2 | Rank |
| evt_grp | input | 2 | Bank group |
| evt_bank | input | 2 | Bank |
| evt_col | input | 10 | Column |
| evt_row | input | 18 | Row |
| irq | output | 1 | Interrupt request |

## Verification
Two cases are hard to reach from the ports. The first is a status clear or interrupt-status clear that meets an error strobe for the same record in the same cycle. The bench holds a register write and an error strobe in one clock to create it. The second is count saturation. To reach it, the bench builds the block with an 8-bit count and sends a burst of 300 strobes to one record. A behavioural model tracks every register and is compared on each clock, both through the read port and through `irq`. Locked writes are aimed at every kind of register and then read back, to show that they left no trace.

// File: rtl/ecc_errlog_pkg.sv
package ecc_errlog_pkg;

   localparam int unsigned OFS_PROT   = 32'h00C;
   localparam int unsigned OFS_ISR    = 32'h014;
   localparam int unsigned OFS_EN_SET = 32'h020;
   localparam int unsigned OFS_EN_CLR = 32'h024;
   localparam int unsigned OFS_LOG    = 32'h100;

   localparam int ISR_LSB  = 11;
   localparam int NUM_SRC  = 4;
   localparam int SRC_W    = $clog2(NUM_SRC);
   localparam int ISR_BITS = 2 * NUM_SRC;

   localparam logic [31:0] UNLOCK_KEY = 32'hF9E8D7C6;
   localparam logic [31:0] RELOCK_VAL = 32'h0000_0001;

   typedef struct packed {
      logic [17:0] row;
      logic [9:0]  col;
      logic [1:0]  bank;
      logic [1:0]  grp;
      logic [1:0]  rank;
      logic [2:0]  lrank;
      logic [2:0]  burst;
   } coord_t;

   localparam int COORD_W = $bits(coord_t);

endpackage

// File: rtl/ecc_errlog_keylock.sv
module ecc_errlog_keylock
   import ecc_errlog_pkg::*;
#(
   parameter logic [31:0] KEY = UNLOCK_KEY
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        prot_wr,
   input  logic [31:0] prot_data,
   output logic        unlocked
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
      end else if (prot_wr) begin
         if (prot_data == KEY)
            unlocked <= 1'b1;
         else if (prot_data == RELOCK_VAL)
            unlocked <= 1'b0;
      end
   end
endmodule

// File: rtl/ecc_errlog_rec.sv
module ecc_errlog_rec
   import ecc_errlog_pkg::*;
#(
   parameter int STAT_W   = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              clr,
   input  coord_t            coord,
   output logic [STAT_W-1:0] stat_q,
   output coord_t            log_q
);
   localparam logic [STAT_W-1:0] STAT_MAX = '1;

   logic [STAT_W-1:0] base;
   logic [STAT_W-1:0] stat_d;
   logic              capture;

   assign base    = clr ? '0 : stat_q;
   assign capture = hit && (base == '0);

   generate
      if (SATURATE) begin : g_count
         assign stat_d = (hit && base != STAT_MAX) ? base + 1'b1 : base;
      end else begin : g_flag
         assign stat_d = hit ? STAT_W'(1) : base;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         log_q  <= '0;
      end else begin
         stat_q <= stat_d;
         if (capture)
            log_q <= coord;
      end
   end
endmodule

// File: rtl/ecc_errlog_irq.sv
module ecc_errlog_irq #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [BITS-1:0] set_vec,
   input  logic [BITS-1:0] clr_vec,
   input  logic [BITS-1:0] en_set,
   input  logic [BITS-1:0] en_clr,
   output logic [BITS-1:0] isr_q,
   output logic [BITS-1:0] en_q,
   output logic            irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q <= '0;
         en_q  <= '0;
      end else begin
         isr_q <= (isr_q & ~clr_vec) | set_vec;
         en_q  <= (en_q | en_set) & ~en_clr;
      end
   end

   assign irq = |(isr_q & en_q);
endmodule

// File: rtl/ecc_errlog_regs.sv
module ecc_errlog_regs
   import ecc_errlog_pkg::*;
#(
   parameter int          NUM_CH   = 2,
   parameter int          ADDR_W   = 12,
   parameter int          STAT_W   = 16,
   parameter bit          SATURATE = 1'b1,
   parameter logic [31:0] KEY      = UNLOCK_KEY,
   localparam int         CH_W     = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              evt_valid,
   input  logic [CH_W-1:0]   evt_chan,
   input  logic              evt_ue,
   input  logic [1:0]        evt_src,
   input  logic [2:0]        evt_burst,
   input  logic [2:0]        evt_lrank,
   input  logic [1:0]        evt_rank,
   input  logic [1:0]        evt_grp,
   input  logic [1:0]        evt_bank,
   input  logic [9:0]        evt_col,
   input  logic [17:0]       evt_row,
   output logic              irq
);
   localparam int NUM_REC = 2 * NUM_CH;
   localparam int REC_W   = CH_W + 1;

   generate
      if (NUM_CH < 2 || NUM_CH > 8) begin : g_bad_ch
         $error("NUM_CH must lie in 2..8");
      end
      if (STAT_W < 1 || STAT_W > 32) begin : g_bad_stat
         $error("STAT_W must lie in 1..32");
      end
      if (OFS_LOG + 32 * NUM_CH > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the log window");
      end
      if (SRC_W != 2) begin : g_bad_src
         $error("source lane field must be 2 bits");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_PROT   = ADDR_W'(OFS_PROT);
   localparam logic [ADDR_W-1:0] A_ISR    = ADDR_W'(OFS_ISR);
   localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFS_EN_SET);
   localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFS_EN_CLR);

   function automatic logic [ADDR_W-1:0] rec_addr(input int rec, input int word);
      return ADDR_W'(OFS_LOG + rec * 16 + word * 4);
   endfunction

   // lock state
   logic unlocked;
   logic wr_ok;

   ecc_errlog_keylock #(.KEY(KEY)) lock_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .prot_wr  (bus_we && bus_addr == A_PROT),
      .prot_data(bus_wdata),
      .unlocked (unlocked)
   );

   assign wr_ok = bus_we && unlocked;

   // error coordinates
   coord_t evt_coord;
   assign evt_coord = '{row: evt_row, col: evt_col, bank: evt_bank, grp: evt_grp,
                        rank: evt_rank, lrank: evt_lrank, burst: evt_burst};

   logic [REC_W-1:0] evt_rec;
   assign evt_rec = {evt_chan, evt_ue};

   // per-record status and log
   logic [STAT_W-1:0] stat   [NUM_REC];
   coord_t            log_q  [NUM_REC];

   generate
      for (genvar r = 0; r < NUM_REC; r++) begin : g_rec
         ecc_errlog_rec #(.STAT_W(STAT_W), .SATURATE(SATURATE)) rec_i (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (evt_valid && evt_rec == REC_W'(r)),
            .clr   (wr_ok && bus_addr == rec_addr(r, 0) && bus_wdata == '0),
            .coord (evt_coord),
            .stat_q(stat[r]),
            .log_q (log_q[r])
         );
      end
   endgenerate

   // interrupt status and enable
   logic [ISR_BITS-1:0] isr_q;
   logic [ISR_BITS-1:0] en_q;
   logic [ISR_BITS-1:0] set_vec;
   logic [ISR_BITS-1:0] wr_field;

   assign wr_field = bus_wdata[ISR_LSB +: ISR_BITS];

   always_comb begin
      set_vec = '0;
      if (evt_valid)
         set_vec[{~evt_ue, evt_src}] = 1'b1;
   end

   ecc_errlog_irq #(.BITS(ISR_BITS)) irq_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .clr_vec((wr_ok && bus_addr == A_ISR)    ? wr_field : '0),
      .en_set ((wr_ok && bus_addr == A_EN_SET) ? wr_field : '0),
      .en_clr ((wr_ok && bus_addr == A_EN_CLR) ? wr_field : '0),
      .isr_q  (isr_q),
      .en_q   (en_q),
      .irq    (irq)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_PROT)
         bus_rdata[0] = ~unlocked;
      if (bus_addr == A_ISR)
         bus_rdata[ISR_LSB +: ISR_BITS] = isr_q;
      if (bus_addr == A_EN_SET)
         bus_rdata[ISR_LSB +: ISR_BITS] = en_q;
      for (int r = 0; r < NUM_REC; r++) begin
         if (bus_addr == rec_addr(r, 0))
            bus_rdata = 32'(stat[r]);
         if (bus_addr == rec_addr(r, 1))
            bus_rdata = log_q[r][31:0];
         if (bus_addr == rec_addr(r, 2))
            bus_rdata = 32'(log_q[r].row[17:10]);
      end
   end
endmodule

// File: rtl/ecc_errlog_chk.sv
module ecc_errlog_chk
   import ecc_errlog_pkg::*;
#(
   parameter int          ADDR_W = 12,
   parameter logic [31:0] KEY    = UNLOCK_KEY
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [31:0]         bus_wdata,
   input logic                evt_valid,
   input logic                evt_ue,
   input logic [1:0]          evt_src,
   input logic                irq,
   input logic                unlocked,
   input logic [ISR_BITS-1:0] isr_q,
   input logic [ISR_BITS-1:0] en_q
);
   // R2
   key_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == ADDR_W'(OFS_PROT) && bus_wdata == KEY |=> unlocked);

   // R2
   relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_addr == ADDR_W'(OFS_PROT) && bus_wdata == 32'd1 |=> !unlocked);

   // R3
   locked_enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(en_q));

   // R3
   locked_isr_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> ((isr_q & $past(isr_q)) == $past(isr_q)));

   // R7
   isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |=> isr_q[{~$past(evt_ue), $past(evt_src)}]);

   // R8
   disable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && unlocked && bus_addr == ADDR_W'(OFS_EN_CLR)
      |=> (en_q & $past(bus_wdata[ISR_LSB +: ISR_BITS])) == '0);

   // R9
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(evt_valid) || $past(bus_we));
endmodule

bind ecc_errlog_regs ecc_errlog_chk #(.ADDR_W(ADDR_W), .KEY(KEY)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .evt_valid(evt_valid),
   .evt_ue   (evt_ue),
   .evt_src  (evt_src),
   .irq      (irq),
   .unlocked (unlocked),
   .isr_q    (isr_q),
   .en_q     (en_q)
);

// File: tb/ecc_errlog_regs_tb_top.sv
`timescale 1ns/1ps
module ecc_errlog_regs_tb_top;
   localparam int TB_STAT_W = 8;
   localparam int STAT_MAX  = (1 << TB_STAT_W) - 1;
   localparam logic [31:0] KEYV = 32'hF9E8D7C6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        evt_valid = 1'b0;
   logic        evt_chan = 1'b0;
   logic        evt_ue = 1'b0;
   logic [1:0]  evt_src = '0;
   logic [2:0]  evt_burst = '0;
   logic [2:0]  evt_lrank = '0;
   logic [1:0]  evt_rank = '0;
   logic [1:0]  evt_grp = '0;
   logic [1:0]  evt_bank = '0;
   logic [9:0]  evt_col = '0;
   logic [17:0] evt_row = '0;
   logic        irq;

   always #2.5 clk = ~clk;

   ecc_errlog_regs #(.STAT_W(TB_STAT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_valid(evt_valid),
      .evt_chan(evt_chan), .evt_ue(evt_ue), .evt_src(evt_src),
      .evt_burst(evt_burst), .evt_lrank(evt_lrank), .evt_rank(evt_rank),
      .evt_grp(evt_grp), .evt_bank(evt_bank), .evt_col(evt_col),
      .evt_row(evt_row), .irq(irq));

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   // behavioural reference model
   bit          m_unl;
   int          m_isr;
   int          m_en;
   int          m_stat [4];
   longint      m_log  [4];

   function automatic int rec_ofs(int rec, int word);
      return 32'h100 + (rec / 2) * 32 + (rec % 2) * 16 + word * 4;
   endfunction

   function automatic longint pack_coord();
      longint v;
      v = longint'(evt_burst) | (longint'(evt_lrank) << 3) | (longint'(evt_rank) << 6)
        | (longint'(evt_grp) << 8) | (longint'(evt_bank) << 10)
        | (longint'(evt_col) << 12) | (longint'(evt_row) << 22);
      return v;
   endfunction

   always @(posedge clk) begin : model
      bit ok;
      int s;
      int er;
      if (!rst_n) begin
         m_unl = 0; m_isr = 0; m_en = 0;
         for (int r = 0; r < 4; r++) begin m_stat[r] = 0; m_log[r] = 0; end
      end else begin
         ok = bus_we && m_unl;
         er = int'(evt_chan) * 2 + int'(evt_ue);
         for (int r = 0; r < 4; r++) begin
            s = m_stat[r];
            if (ok && int'(bus_addr) == rec_ofs(r, 0) && bus_wdata == 0) s = 0;
            if (evt_valid && r == er) begin
               if (s == 0) m_log[r] = pack_coord();
               if (s < STAT_MAX) s = s + 1;
            end
            m_stat[r] = s;
         end
         if (ok && bus_addr == 12'h014) m_isr = m_isr & ~int'(bus_wdata[18:11]);
         if (evt_valid) m_isr = m_isr | (1 << ((evt_ue ? 0 : 4) + int'(evt_src)));
         if (ok && bus_addr == 12'h020) m_en = m_en | int'(bus_wdata[18:11]);
         if (ok && bus_addr == 12'h024) m_en = m_en & ~int'(bus_wdata[18:11]);
         if (bus_we && bus_addr == 12'h00C) begin
            if (bus_wdata == KEYV) m_unl = 1;
            else if (bus_wdata == 32'd1) m_unl = 0;
         end
      end
   end

   function automatic logic [31:0] m_read(logic [11:0] a);
      logic [31:0] v;
      v = '0;
      if (a == 12'h00C) v = m_unl ? 32'd0 : 32'd1;
      if (a == 12'h014) v = 32'(m_isr) << 11;
      if (a == 12'h020) v = 32'(m_en) << 11;
      for (int r = 0; r < 4; r++) begin
         if (int'(a) == rec_ofs(r, 0)) v = 32'(m_stat[r]);
         if (int'(a) == rec_ofs(r, 1)) v = m_log[r][31:0];
         if (int'(a) == rec_ofs(r, 2)) v = 32'(m_log[r][39:32]);
      end
      return v;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=0x%08h expected=0x%08h t=%0t", req, act, exp, $time);
      end
   endtask

   // one clock; compare against the model every cycle
   task automatic tick();
      @(negedge clk);
      chk("R9 model irq", 32'(irq), 32'((m_isr & m_en) != 0));
      chk("R11 model read", bus_rdata, m_read(bus_addr));
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_we = 1'b0;
   endtask

   task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
      bus_addr = a;
      tick();
      chk(req, bus_rdata, exp);
   endtask

   task automatic set_evt(logic ch, logic ue, logic [1:0] src, logic [2:0] bu,
                          logic [2:0] lr, logic [1:0] rk, logic [1:0] gp,
                          logic [1:0] bk, logic [9:0] cl, logic [17:0] rw);
      evt_chan = ch; evt_ue = ue; evt_src = src; evt_burst = bu; evt_lrank = lr;
      evt_rank = rk; evt_grp = gp; evt_bank = bk; evt_col = cl; evt_row = rw;
   endtask

   task automatic fire();
      evt_valid = 1'b1;
      tick();
      evt_valid = 1'b0;
   endtask

   function automatic logic [31:0] exp_lo(logic [2:0] bu, logic [2:0] lr, logic [1:0] rk,
                                          logic [1:0] gp, logic [1:0] bk, logic [9:0] cl,
                                          logic [17:0] rw);
      return {rw[9:0], cl, bk, gp, rk, lr, bu};
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", 32'(irq), 32'd0);
      rd("R1 prot", 12'h00C, 32'd1);
      rd("R1 isr", 12'h014, 32'd0);
      rd("R1 enable", 12'h020, 32'd0);
      rd("R1 stat", 12'h100, 32'd0);
      rd("R1 stat", 12'h130, 32'd0);

      // R3 locked writes dropped
      wr(12'h020, 32'hFFFF_FFFF);
      rd("R3 enable locked", 12'h020, 32'd0);

      // R4/R7 first correctable error on ch0 lane 0
      set_evt(1'b0, 1'b0, 2'd0, 3'd5, 3'd3, 2'd2, 2'd1, 2'd3, 10'h2A5, 18'h2F0F3);
      fire();
      rd("R4 count", 12'h100, 32'd1);
      rd("R7 isr ce lane0", 12'h014, 32'h0000_8000);
      chk("R9 masked", 32'(irq), 32'd0);
      rd("R5 lo", 12'h104, exp_lo(3'd5, 3'd3, 2'd2, 2'd1, 2'd3, 10'h2A5, 18'h2F0F3));
      rd("R5 hi", 12'h108, 32'h0000_00BC);

      wr(12'h100, 32'd0);
      rd("R3 stat locked", 12'h100, 32'd1);
      wr(12'h014, 32'h0000_8000);
      rd("R3 isr locked", 12'h014, 32'h0000_8000);

      // R2 unlock
      wr(12'h00C, 32'h0000_1234);
      rd("R2 bad key", 12'h00C, 32'd1);
      wr(12'h00C, KEYV);
      rd("R2 unlocked", 12'h00C, 32'd0);

      // R8/R9 enables
      wr(12'h020, 32'hFFFF_FFFF);
      rd("R8 enable set", 12'h020, 32'h0007_F800);
      chk("R9 irq on", 32'(irq), 32'd1);
      wr(12'h024, 32'h0000_8000);
      rd("R8 enable clr", 12'h020, 32'h0007_7800);
      rd("R8 dis reads 0", 12'h024, 32'd0);
      chk("R9 irq off", 32'(irq), 32'd0);

      // uncorrectable on ch1 lane 3
      set_evt(1'b1, 1'b1, 2'd3, 3'd1, 3'd6, 2'd1, 2'd2, 2'd0, 10'h15A, 18'h1C3A5);
      fire();
      chk("R9 ue irq", 32'(irq), 32'd1);
      rd("R7 isr ue lane3", 12'h014, 32'h0000_C000);
      rd("R11 ch1 ue count", 12'h130, 32'd1);
      rd("R5 ch1 ue lo", 12'h134, exp_lo(3'd1, 3'd6, 2'd1, 2'd2, 2'd0, 10'h15A, 18'h1C3A5));
      rd("R5 ch1 ue hi", 12'h138, 32'h0000_0070);
      set_evt(1'b1, 1'b1, 2'd3, 3'd7, 3'd7, 2'd3, 2'd3, 2'd3, 10'h3FF, 18'h3FFFF);
      fire();
      rd("R4 count two", 12'h130, 32'd2);
      rd("R5 log kept", 12'h134, exp_lo(3'd1, 3'd6, 2'd1, 2'd2, 2'd0, 10'h15A, 18'h1C3A5));

      // R6 clear semantics
      wr(12'h130, 32'd5);
      rd("R6 nonzero ignored", 12'h130, 32'd2);
      wr(12'h130, 32'd0);
      rd("R6 cleared", 12'h130, 32'd0);
      fire();
      rd("R5 relogged", 12'h134, exp_lo(3'd7, 3'd7, 2'd3, 2'd3, 2'd3, 10'h3FF, 18'h3FFFF));
      rd("R5 relogged hi", 12'h138, 32'h0000_00FF);

      // R10 clear and error in the same cycle
      set_evt(1'b1, 1'b1, 2'd3, 3'd2, 3'd0, 2'd0, 2'd0, 2'd1, 10'h001, 18'h00400);
      bus_we = 1'b1; bus_addr = 12'h130; bus_wdata = 32'd0; evt_valid = 1'b1;
      tick();
      bus_we = 1'b0; evt_valid = 1'b0;
      rd("R10 count", 12'h130, 32'd1);
      rd("R10 log", 12'h134, exp_lo(3'd2, 3'd0, 2'd0, 2'd0, 2'd1, 10'h001, 18'h00400));

      // R7 write-one-to-clear, with set winning
      wr(12'h014, 32'h0000_4000);
      rd("R7 w1c", 12'h014, 32'h0000_8000);
      set_evt(1'b0, 1'b0, 2'd0, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 10'h0, 18'h0);
      bus_we = 1'b1; bus_addr = 12'h014; bus_wdata = 32'h0000_8000; evt_valid = 1'b1;
      tick();
      bus_we = 1'b0; evt_valid = 1'b0;
      rd("R7 set wins", 12'h014, 32'h0000_8000);
      wr(12'h014, 32'h0000_8000);
      rd("R7 cleared", 12'h014, 32'h0000_0000);

      // R11 unmapped and other records
      rd("R11 unmapped", 12'h200, 32'd0);
      rd("R11 unmapped", 12'h010, 32'd0);
      rd("R11 ch0 ue", 12'h110, 32'd0);

      // R4 saturation on ch1 correctable lane 1
      set_evt(1'b1, 1'b0, 2'd1, 3'd4, 3'd1, 2'd0, 2'd3, 2'd2, 10'h0F0, 18'h00F0F);
      evt_valid = 1'b1;
      for (int i = 0; i < 300; i++) tick();
      evt_valid = 1'b0;
      rd("R4 saturated", 12'h120, 32'(STAT_MAX));
      rd("R7 ce lane1", 12'h014, 32'h0001_0000);

      // R2/R3 relock
      wr(12'h00C, 32'd1);
      rd("R2 relocked", 12'h00C, 32'd1);
      wr(12'h024, 32'hFFFF_FFFF);
      rd("R3 enable kept", 12'h020, 32'h0007_7800);
      wr(12'h120, 32'd0);
      rd("R3 count kept", 12'h120, 32'(STAT_MAX));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule